// File: doc/BRIEF.md
# Slow-Clock Watchdog Reset Timer

This block is a watchdog that runs directly on a 32768 Hz slow clock and pulls a system reset line when software stops servicing it. Software programs a shadow mode register with a timeout count and a reset-arm flag. It then issues a restart command through a control register. The restart copies the shadow value into the live down-counter. The counter steps down once per unit of 128 slow-clock ticks, which is about 3.9 ms, so a count of 2^15 gives a timeout of roughly two minutes.

The counter runs only between restart commands. A new shadow value has no effect until the next restart, and a count of zero leaves the watchdog idle. When the live count runs out and the arm flag was set at the last restart, the reset output goes high. It stays high until the next restart. If the arm flag was clear, the counter expires quietly and holds at zero.

Register accesses are single-cycle write strobes in the slow-clock domain.

Top module: `slow_wdt`

## Requirements
- R1: After rstN is released, resetOut is low, and it stays low for as long as no restart command is written.
- R2: A write with wrAddr=0 loads the shadow mode register. Bits [15:0] of wrData are the count and bit 16 is the reset-arm flag; higher bits are ignored. A write with wrAddr=1 is a control write, and a control write with wrData bit 0 set is a restart command.
- R3: A restart loads the live count from the shadow count and clears the 7-bit prescaler. With a count of N, the counter reaches zero exactly 128*N clock edges after the edge that samples the restart write.
- R4: If the arm flag was set at the last restart, resetOut rises on the edge where the count reaches zero. It then stays high, and the count stays at zero, until the next restart.
- R5: If the arm flag was clear at the last restart, expiry leaves resetOut low.
- R6: A restart taken while the shadow count is zero leaves the watchdog idle, and it never drives resetOut high, whatever the arm flag says.
- R7: A mode write during a running count changes neither the current count nor its expiry time. The new value is used from the next restart on.
- R8: A restart before expiry reloads the count, so expiry moves to 128*N edges after that restart.
- R9: A restart while resetOut is high drops resetOut on the edge that samples it, and a new count starts from that edge.
- R10: A control write with bit 0 clear has no effect on a running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz slow clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Single-cycle register write strobe |
| wrAddr | input | 1 | 0 selects the mode register, 1 selects the control register |
| wrData | input | 32 | Write data |
| resetOut | output | 1 | System reset request, active high |

## Verification
The bench checks the reset line one tick before and at the exact expiry edge, for counts of 1, 2, 3 and 8 units. A design whose prescaler is not cleared on restart, or whose count is off by one, shows the edge in the wrong place. Shadow writes are made in the middle of a count: a design that applies them at once expires at the wrong time. Restarts are issued both before and after expiry, which exposes designs that do not reload or do not release the reset. Runs with the arm flag clear, with a zero count, and with a control write whose restart bit is clear must never raise the reset line; a design that ignores the arm bit or the bit position fires in these runs.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic modeWr;   // capture shadow mode value
    logic reload;   // copy shadow into live counter, clear prescaler
    logic tickEn;   // advance prescaler / counter
  } wdtStrobe_t;

  typedef enum logic [1:0] {
    WD_IDLE  = 2'd0,
    WD_RUN   = 2'd1,
    WD_FIRED = 2'd2
  } wdtState_e;

endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PRESC_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdtStrobe_t       st,
  input  logic [CNT_W:0]   modeIn,     // {armFlag, count}
  output logic             modeZero,
  output logic             unitEnd,
  output logic             lastUnit,
  output logic             armRst,
  output logic [CNT_W-1:0] cntNow,
  output logic [PRESC_W-1:0] presc,
  output logic [CNT_W-1:0] modeCount
);
  localparam int EN_BIT = CNT_W;
  localparam logic [PRESC_W-1:0] PRESC_TOP = {PRESC_W{1'b1}};
  localparam logic [CNT_W-1:0]   ONE_CNT   = {{(CNT_W-1){1'b0}}, 1'b1};

  logic modeArm;

  // shadow mode register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeCount <= '0;
      modeArm   <= 1'b0;
    end else if (st.modeWr) begin
      modeCount <= modeIn[CNT_W-1:0];
      modeArm   <= modeIn[EN_BIT];
    end
  end

  // prescaler: one unit per wrap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          presc <= '0;
    else if (st.reload) presc <= '0;
    else if (st.tickEn) presc <= presc + 1'b1;
  end

  // live down-counter and latched arm flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntNow <= '0;
      armRst <= 1'b0;
    end else if (st.reload) begin
      cntNow <= modeCount;
      armRst <= modeArm;
    end else if (st.tickEn && unitEnd && cntNow != '0) begin
      cntNow <= cntNow - 1'b1;
    end
  end

  assign modeZero = (modeCount == '0);
  assign unitEnd  = (presc == PRESC_TOP);
  assign lastUnit = (cntNow == ONE_CNT);

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrAddr,
  input  logic       restartBit,
  input  logic       modeZero,
  input  logic       unitEnd,
  input  logic       lastUnit,
  input  logic       armRst,
  output wdtStrobe_t st,
  output logic       resetOut
);
  wdtState_e state;
  logic      reload;

  assign reload    = wrEn && wrAddr && restartBit;
  assign st.modeWr = wrEn && !wrAddr;
  assign st.reload = reload;
  assign st.tickEn = (state == WD_RUN) && !reload;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= WD_IDLE;
      resetOut <= 1'b0;
    end else if (reload) begin
      state    <= modeZero ? WD_IDLE : WD_RUN;
      resetOut <= 1'b0;
    end else if (state == WD_RUN && unitEnd && lastUnit) begin
      state    <= WD_FIRED;
      resetOut <= armRst;
    end
  end

endmodule

// File: rtl/slow_wdt.sv
module slow_wdt
  import wdt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PRESC_W = 7,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              resetOut
);
  wdtStrobe_t         st;
  logic               modeZero, unitEnd, lastUnit, armRst;
  logic [CNT_W-1:0]   cntNow, modeCount;
  logic [PRESC_W-1:0] presc;
  logic               unusedBits;

  assign unusedBits = ^wrData[DATA_W-1:CNT_W+1];

  wdt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .restartBit(wrData[0]), .modeZero(modeZero), .unitEnd(unitEnd),
    .lastUnit(lastUnit), .armRst(armRst), .st(st), .resetOut(resetOut)
  );

  wdt_datapath #(.CNT_W(CNT_W), .PRESC_W(PRESC_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .modeIn(wrData[CNT_W:0]),
    .modeZero(modeZero), .unitEnd(unitEnd), .lastUnit(lastUnit),
    .armRst(armRst), .cntNow(cntNow), .presc(presc), .modeCount(modeCount)
  );

endmodule

// File: rtl/slow_wdt_chk.sv
module slow_wdt_chk #(
  parameter int CNT_W   = 16,
  parameter int PRESC_W = 7
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic               wrAddr,
  input logic               restartBit,
  input logic               resetOut,
  input logic [CNT_W-1:0]   cntNow,
  input logic [PRESC_W-1:0] presc,
  input logic [CNT_W-1:0]   modeCount
);
  logic restartSeen;
  assign restartSeen = wrEn && wrAddr && restartBit;

  p_reload_count_r3: assert property (@(posedge clk) disable iff (!rstN)
    restartSeen |=> cntNow == $past(modeCount));

  p_presc_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    restartSeen |=> presc == '0);

  p_reset_at_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    resetOut |-> cntNow == '0);

  p_reset_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (resetOut && !restartSeen) |=> resetOut);

  p_fire_on_unit_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetOut) |-> $past(presc) == {PRESC_W{1'b1}});

  p_count_holds_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cntNow == '0 && !restartSeen) |=> cntNow == '0);

  p_count_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!restartSeen) |=> (cntNow == $past(cntNow) || cntNow == $past(cntNow) - 1'b1));

  p_restart_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    restartSeen |=> !resetOut);

endmodule

bind slow_wdt slow_wdt_chk #(.CNT_W(CNT_W), .PRESC_W(PRESC_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
  .restartBit(wrData[0]), .resetOut(resetOut), .cntNow(cntNow),
  .presc(presc), .modeCount(modeCount)
);

// File: tb/slow_wdt_bench.sv
module slow_wdt_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ARM = 32'h0001_0000;

  typedef struct {
    int unsigned cyc;
    logic        val;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrAddr = 1'b0;
  logic [31:0] wrData = '0;
  logic        resetOut;

  int unsigned cyc = 0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;
  expItem_t    q[$];

  slow_wdt u_slow_wdt (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .resetOut(resetOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare resetOut at the cycle each expectation names
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      expItem_t it;
      it = q.pop_front();
      checks++;
      if (it.cyc != cyc) begin
        errors++;
        $display("FAIL %s: check missed at cycle %0d (expected cycle %0d)", it.tag, cyc, it.cyc);
      end else if (resetOut !== it.val) begin
        errors++;
        $display("FAIL %s: cycle %0d resetOut actual=%b expected=%b", it.tag, cyc, resetOut, it.val);
      end
    end
  end

  task automatic expectAt(input int unsigned offs, input logic v, input string tag);
    expItem_t it;
    it.cyc = cyc + offs;
    it.val = v;
    it.tag = tag;
    q.push_back(it);
  endtask

  // drive one write; returns at the negedge right after the sampling edge
  task automatic writeReg(input logic a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; wrAddr = 1'b0; wrData = '0;
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: idle after reset, no restart
    expectAt(0, 1'b0, "R1");
    expectAt(300, 1'b0, "R1");
    drain();

    // R2 R3 R4: count 1, armed
    writeReg(1'b0, ARM | 32'd1);
    writeReg(1'b1, 32'd1);
    expectAt(127, 1'b0, "R3");
    expectAt(128, 1'b1, "R4");
    expectAt(200, 1'b1, "R4");
    drain();

    // R9: restart while fired clears at once, new count runs
    writeReg(1'b1, 32'd1);
    expectAt(0, 1'b0, "R9");
    expectAt(127, 1'b0, "R9");
    expectAt(128, 1'b1, "R9");
    drain();

    // R7: mode write mid-count does not change expiry of count 2
    writeReg(1'b0, ARM | 32'd2);
    writeReg(1'b1, 32'd1);
    expectAt(255, 1'b0, "R7");
    expectAt(256, 1'b1, "R7");
    waitCyc(50);
    writeReg(1'b0, ARM | 32'd8);
    drain();
    // new shadow (8 units) used at next restart
    writeReg(1'b1, 32'd1);
    expectAt(1023, 1'b0, "R7");
    expectAt(1024, 1'b1, "R7");
    drain();

    // R8: early restart pushes expiry out
    writeReg(1'b0, ARM | 32'd2);
    writeReg(1'b1, 32'd1);
    expectAt(256, 1'b0, "R8");
    waitCyc(199);
    writeReg(1'b1, 32'd1);
    expectAt(255, 1'b0, "R8");
    expectAt(256, 1'b1, "R8");
    drain();

    // R5: unarmed expiry stays quiet
    writeReg(1'b0, 32'd1);
    writeReg(1'b1, 32'd1);
    expectAt(0, 1'b0, "R5");
    expectAt(128, 1'b0, "R5");
    expectAt(300, 1'b0, "R5");
    drain();

    // R6: zero count with arm flag never fires
    writeReg(1'b0, ARM);
    writeReg(1'b1, 32'd1);
    expectAt(128, 1'b0, "R6");
    expectAt(600, 1'b0, "R6");
    drain();

    // R2: high garbage ignored, bit 16 clear means unarmed
    writeReg(1'b0, 32'hFFFE_0001);
    writeReg(1'b1, 32'd1);
    expectAt(128, 1'b0, "R2");
    expectAt(200, 1'b0, "R2");
    drain();

    // R2: count above bit 0 honoured (3 units)
    writeReg(1'b0, ARM | 32'd3);
    writeReg(1'b1, 32'd1);
    expectAt(383, 1'b0, "R2");
    expectAt(384, 1'b1, "R2");
    drain();

    // R10: control write with bit 0 clear is ignored
    writeReg(1'b0, ARM | 32'd1);
    writeReg(1'b1, 32'd1);
    expectAt(127, 1'b0, "R10");
    expectAt(128, 1'b1, "R10");
    waitCyc(59);
    writeReg(1'b1, 32'hFFFF_FFFE);
    drain();

    finishRun();
  end

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      finishRun();
    end
  end

endmodule